// File: doc/BRIEF.md
# Memory Controller Performance Counter Bank

This block is a small bank of event counters that sits beside a memory controller and measures its activity. The controller delivers a vector of one-cycle event strobes plus the IDs of read and write transactions as they are accepted. Software programs each counter through a plain word-wide register port. A counter is given an 8-bit event code, then enabled and zeroed. It can read the running value at any time.

Slot 0 is hard-wired to count clock cycles and acts as the master of the bank. The other slots advance only while slot 0 is running. When slot 0 wraps past its top value, the whole bank freezes and an interrupt line rises. It stays high until software acknowledges it. The other slots wrap without any interrupt. Two event codes count only those read or write transactions whose ID passes a programmable compare-under-mask filter.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset every count reads 0, control word 0 reads 0x0000_0000, control words 1..3 read 0x0000_0002, the filter word reads 0 and `irq` is low.
- R2: Slot n's control word is at byte address 4*n, its count is at 0x20 + 4*n, and the filter word is at 0x30. Any other address reads 0. Reads are combinational on `reg_addr`.
- R3: Control word layout: bit 0 is the sticky wrap flag, bit 1 is the zeroing control, bit 2 is the enable, and bits 31:24 are the event code. All other bits read 0.
- R4: A slot n>=1 adds one on every clock edge at which it is enabled, the bank is running, and its selected event is true. Code 0 is true every cycle. A code c below NUM_EVT (default 64) selects `evt_strobe[c]`.
- R5: Slot 0 ignores the written event code, reads it back as 0, and always counts cycles.
- R6: Slot 0 is zeroed when a write raises its zeroing bit from 0 to 1. It counts only while both its enable bit and its zeroing bit are 1.
- R7: Writing a control word of slot n>=1 with bit 1 = 0 zeroes that count, and bit 1 then reads back as 1. A write with bit 1 = 1 leaves the count alone.
- R8: Slots 1..3 hold their values whenever slot 0 is not running, meaning its enable or zeroing bit is 0 or its wrap flag is set. They resume when slot 0 runs again.
- R9: When slot 0 steps from all-ones, it reads 0, its wrap flag is set, `irq` goes high, and every slot freezes.
- R10: `irq` follows slot 0's wrap flag. A write to control word 0 with bit 0 = 0 clears it. A write with bit 0 = 1 leaves it set.
- R11: A slot n>=1 that steps from all-ones continues from 0 and sets its own wrap flag, with no effect on `irq`.
- R12: Code 0x41 counts cycles with `rd_txn_valid` high, and code 0x42 counts cycles with `wr_txn_valid` high, in each case only when (id & M) == (F & M). F is filter bits 15:0 and M is filter bits 31:16. The filter word reads back as written.
- R13: A code that is neither 0, 0x41 nor 0x42 and is not below NUM_EVT never advances a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte address for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_strobe | input | NUM_EVT | One-cycle event strobes from the controller |
| rd_txn_valid | input | 1 | A read transaction is accepted this cycle |
| rd_txn_id | input | ID_W | ID of that read transaction |
| wr_txn_valid | input | 1 | A write transaction is accepted this cycle |
| wr_txn_id | input | ID_W | ID of that write transaction |
| irq | output | 1 | Level interrupt raised by a slot 0 wrap |

## Verification
The hardest condition to reach from the ports is a wrap of the cycle slot. At full width it takes four billion cycles, and without it the freeze, the interrupt and the acknowledge cannot be observed. The bench therefore builds the bank with an 8-bit counter width. It starts slot 1 one cycle after slot 0, so that slot 1 sits exactly at all-ones when the bank freezes. Releasing the freeze then makes slot 1 wrap on its own, which shows a silent wrap next to an acknowledged one.

// File: rtl/perf_pkg.sv
// perf_pkg: register map, control bit positions and reserved event codes
// shared by every module of the counter bank.
package perf_pkg;
    localparam int ADDR_W       = 8;
    localparam int DATA_W       = 32;
    localparam int CTRL_BASE    = 'h00;
    localparam int CNT_BASE     = 'h20;
    localparam int FILT_ADDR    = 'h30;
    localparam int B_WRAP       = 0;
    localparam int B_ZERO       = 1;
    localparam int B_EN         = 2;
    localparam int CODE_LSB     = 24;
    localparam int CODE_W       = 8;

    typedef logic [CODE_W-1:0] evt_code_t;

    localparam evt_code_t CODE_CYCLES = 8'h00;
    localparam evt_code_t CODE_RD_ID  = 8'h41;
    localparam evt_code_t CODE_WR_ID  = 8'h42;
endpackage

// File: rtl/perf_id_filter.sv
// perf_id_filter: holds the compare/mask word and qualifies read and write
// transactions by ID. Assumes ID_W <= 16 so the word fits the data bus.
module perf_id_filter
    import perf_pkg::*;
#(
    parameter int ID_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_valid,
    input  logic [ID_W-1:0]   rd_id,
    input  logic              wr_valid,
    input  logic [ID_W-1:0]   wr_id,
    output logic [DATA_W-1:0] word_o,
    output logic              rd_hit,
    output logic              wr_hit
);
    logic [2*ID_W-1:0] word_q;
    logic [ID_W-1:0]   ref_id;
    logic [ID_W-1:0]   care;

    // Store the compare/mask word as software wrote it.
    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else if (wr_en) word_q <= wdata[2*ID_W-1:0];
    end

    assign ref_id = word_q[ID_W-1:0];
    assign care   = word_q[2*ID_W-1:ID_W];
    assign word_o = DATA_W'(word_q);

    // Compare only the bits the mask marks as significant.
    always_comb begin
        rd_hit = rd_valid && (((rd_id ^ ref_id) & care) == '0);
        wr_hit = wr_valid && (((wr_id ^ ref_id) & care) == '0);
    end
endmodule

// File: rtl/perf_evt_select.sv
// perf_evt_select: turns a slot's event code into a per-cycle hit.
// Assumes NUM_EVT is a power of two no greater than 256.
module perf_evt_select
    import perf_pkg::*;
#(
    parameter int NUM_EVT = 64
) (
    input  evt_code_t          code,
    input  logic [NUM_EVT-1:0] evt_strobe,
    input  logic               rd_id_hit,
    input  logic               wr_id_hit,
    output logic               hit
);
    localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    // Reserved codes first, then the plain strobe vector, else never.
    always_comb begin
        if (code == CODE_CYCLES)
            hit = 1'b1;
        else if (code == CODE_RD_ID)
            hit = rd_id_hit;
        else if (code == CODE_WR_ID)
            hit = wr_id_hit;
        else if (32'(code) < 32'(NUM_EVT))
            hit = evt_strobe[code[IDX_W-1:0]];
        else
            hit = 1'b0;
    end
endmodule

// File: rtl/perf_counter_slot.sv
// perf_counter_slot: one counter and its control word. IS_CYCLE selects
// the master variant (code fixed to cycles, zeroed on a 0->1 write of the
// zeroing bit). A write takes priority over counting only for zeroing.
module perf_counter_slot
    import perf_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter bit IS_CYCLE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hit,
    input  logic              bank_run,
    output logic [CNT_W-1:0]  count_o,
    output logic              wrap_o,
    output logic              en_o,
    output logic              zero_o,
    output evt_code_t         code_o
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             wrap_q;
    logic             en_q;
    logic             zero_q;
    evt_code_t        code_q;
    logic             clear_now;
    logic             step;
    logic             rollover;

    // Decide what counts as a zeroing request for this variant.
    generate
        if (IS_CYCLE) begin : g_master
            assign clear_now = wr_ctrl && !zero_q && wdata[B_ZERO];
        end else begin : g_plain
            assign clear_now = wr_ctrl && !wdata[B_ZERO];
        end
    endgenerate

    assign step     = en_q && bank_run && hit && !clear_now;
    assign rollover = step && (cnt_q == TOP);

    // Counter value: zero on request, otherwise advance on a qualified cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (clear_now) cnt_q <= '0;
        else if (step)      cnt_q <= cnt_q + CNT_W'(1);
    end

    // Sticky wrap flag: written 0 clears it, a rollover sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) wrap_q <= 1'b0;
        else        wrap_q <= (wr_ctrl ? (wrap_q & wdata[B_WRAP]) : wrap_q) | rollover;
    end

    // Control fields captured from a control-word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            zero_q <= !IS_CYCLE;
            code_q <= CODE_CYCLES;
        end else if (wr_ctrl) begin
            en_q   <= wdata[B_EN];
            zero_q <= IS_CYCLE ? wdata[B_ZERO] : 1'b1;
            code_q <= IS_CYCLE ? CODE_CYCLES : wdata[CODE_LSB +: CODE_W];
        end
    end

    assign count_o = cnt_q;
    assign wrap_o  = wrap_q;
    assign en_o    = en_q;
    assign zero_o  = zero_q;
    assign code_o  = code_q;

    // R6/R7: a zeroing request leaves the count at zero.
    p_zeroed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_now |=> (cnt_q == '0));

    // R4: a qualified cycle below the top adds exactly one.
    p_add_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !rollover) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R8: while the bank is halted and nothing zeroes the slot, it holds.
    p_hold_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_run && !clear_now) |=> $stable(cnt_q));

    // R11: a rollover lands on zero with the flag raised.
    p_wrap_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rollover |=> (wrap_q && cnt_q == '0));
endmodule

// File: rtl/perf_counter_bank.sv
// perf_counter_bank: NUM_CNT counter slots, the ID filter and the register
// port. Slot 0 is the cycle master whose run state gates the others.
// Assumes NUM_CNT <= 4 and CNT_W <= 32 to fit the fixed register map.
module perf_counter_bank
    import perf_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 64,
    parameter int ID_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_EVT-1:0] evt_strobe,
    input  logic               rd_txn_valid,
    input  logic [ID_W-1:0]    rd_txn_id,
    input  logic               wr_txn_valid,
    input  logic [ID_W-1:0]    wr_txn_id,
    output logic               irq
);
    logic [CNT_W-1:0]  cnt   [NUM_CNT];
    logic              wrapf [NUM_CNT];
    logic              en    [NUM_CNT];
    logic              zero  [NUM_CNT];
    evt_code_t         code  [NUM_CNT];
    logic              hit   [NUM_CNT];
    logic              wr_ctrl [NUM_CNT];
    logic              bank_run;
    logic              rd_id_hit;
    logic              wr_id_hit;
    logic [DATA_W-1:0] filt_word;

    perf_id_filter #(.ID_W(ID_W)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we && (reg_addr == ADDR_W'(FILT_ADDR))),
        .wdata    (reg_wdata),
        .rd_valid (rd_txn_valid),
        .rd_id    (rd_txn_id),
        .wr_valid (wr_txn_valid),
        .wr_id    (wr_txn_id),
        .word_o   (filt_word),
        .rd_hit   (rd_id_hit),
        .wr_hit   (wr_id_hit)
    );

    // The master slot runs only when enabled, armed and not wrapped.
    assign bank_run = en[0] && zero[0] && !wrapf[0];
    assign irq      = wrapf[0];

    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_slot
            assign wr_ctrl[i] = reg_we && (reg_addr == ADDR_W'(CTRL_BASE + 4*i));

            perf_evt_select #(.NUM_EVT(NUM_EVT)) u_sel (
                .code       (code[i]),
                .evt_strobe (evt_strobe),
                .rd_id_hit  (rd_id_hit),
                .wr_id_hit  (wr_id_hit),
                .hit        (hit[i])
            );

            perf_counter_slot #(.CNT_W(CNT_W), .IS_CYCLE(i == 0)) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_ctrl  (wr_ctrl[i]),
                .wdata    (reg_wdata),
                .hit      (hit[i]),
                .bank_run (bank_run),
                .count_o  (cnt[i]),
                .wrap_o   (wrapf[i]),
                .en_o     (en[i]),
                .zero_o   (zero[i]),
                .code_o   (code[i])
            );
        end
    endgenerate

    // Combinational read mux over control, count and filter words.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(FILT_ADDR))
            reg_rdata = filt_word;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (reg_addr == ADDR_W'(CTRL_BASE + 4*i))
                reg_rdata = {code[i], 21'd0, en[i], zero[i], wrapf[i]};
            if (reg_addr == ADDR_W'(CNT_BASE + 4*i))
                reg_rdata = DATA_W'(cnt[i]);
        end
    end

    // R10: the interrupt persists until control word 0 is written with bit 0 low.
    p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr_ctrl[0] && !reg_wdata[B_WRAP])) |=> irq);

    // R10: an acknowledging write drops the interrupt on the next edge.
    p_irq_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && wr_ctrl[0] && !reg_wdata[B_WRAP]) |=> !irq);

    // R9: the interrupt rises only through a rollover of the master slot.
    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(cnt[0]) == '1 && cnt[0] == '0));
endmodule

// File: tb/tb_perf_counter_bank.sv
module tb_perf_counter_bank;
    localparam int CW = 8;
    localparam int NE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NE-1:0] evt_strobe = '0;
    logic        rd_txn_valid = 1'b0;
    logic [15:0] rd_txn_id = '0;
    logic        wr_txn_valid = 1'b0;
    logic [15:0] wr_txn_id = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    perf_counter_bank #(.NUM_CNT(4), .CNT_W(CW), .NUM_EVT(NE), .ID_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_strobe(evt_strobe),
        .rd_txn_valid(rd_txn_valid), .rd_txn_id(rd_txn_id),
        .wr_txn_valid(wr_txn_valid), .wr_txn_id(wr_txn_id), .irq(irq)
    );

    typedef struct packed {
        logic [7:0]  code;
        logic [15:0] pattern;
        logic [7:0]  cycles;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{code: 8'h03, pattern: 16'h0008, cycles: 8'd10},
        '{code: 8'h03, pattern: 16'hFFF7, cycles: 8'd10},
        '{code: 8'h0F, pattern: 16'h8000, cycles: 8'd25},
        '{code: 8'h20, pattern: 16'hFFFF, cycles: 8'd12},
        '{code: 8'h07, pattern: 16'h0080, cycles: 8'd1},
        '{code: 8'h41, pattern: 16'hFFFF, cycles: 8'd9},
        '{code: 8'h05, pattern: 16'h0060, cycles: 8'd30}
    };

    // Caller sits just after a falling edge; the write lands on the next rise.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1/R2: reset values and the unmapped addresses.
        chk("R1 ctrl0", 8'h00, 32'h0);
        chk("R1 ctrl1", 8'h04, 32'h2);
        chk("R1 ctrl3", 8'h0C, 32'h2);
        chk("R1 count0", 8'h20, 32'h0);
        chk("R1 filter", 8'h30, 32'h0);
        chk_irq("R1 irq", 1'b0);
        chk("R2 unmapped 0x3C", 8'h3C, 32'h0);
        chk("R2 unmapped 0x10", 8'h10, 32'h0);
        @(negedge clk);

        // R5/R3/R6: master code ignored, zeroing on a 0->1 write.
        wr(8'h00, 32'hAB00_0000);
        chk("R5 master code reads 0", 8'h00, 32'h0);
        wr(8'h00, 32'hAB00_0006);
        chk("R3 master ctrl layout", 8'h00, 32'h0000_0006);
        idle(5);
        chk("R6 master counts cycles", 8'h20, 32'd5);
        wr(8'h00, 32'h0000_0004);
        idle(4);
        chk("R6 master halts with zeroing bit 0", 8'h20, 32'd6);
        wr(8'h00, 32'h0000_0006);
        chk("R6 master rezeroed", 8'h20, 32'd0);

        // R7: zeroing and non-zeroing writes of a plain slot.
        wr(8'h04, 32'h0500_0004);
        chk("R7 ctrl1 zero bit reads 1", 8'h04, 32'h0500_0006);
        evt_strobe = 16'h0020;
        idle(3);
        evt_strobe = '0;
        chk("R4 slot1 three strobes", 8'h24, 32'd3);
        wr(8'h04, 32'h0500_0006);
        chk("R7 write with bit1=1 keeps count", 8'h24, 32'd3);
        wr(8'h04, 32'h0500_0004);
        chk("R7 write with bit1=0 zeroes", 8'h24, 32'd0);

        // R4/R13/R12: table of codes and strobe patterns on slot 1.
        for (int v = 0; v < 7; v++) begin
            automatic int exp;
            wr(8'h00, 32'h0);
            wr(8'h00, 32'h6);
            wr(8'h04, {VECS[v].code, 24'h000004});
            evt_strobe = VECS[v].pattern;
            idle(int'(VECS[v].cycles));
            evt_strobe = '0;
            if (VECS[v].code == 8'h00)
                exp = int'(VECS[v].cycles);
            else if (VECS[v].code < 8'(NE))
                exp = VECS[v].pattern[VECS[v].code[3:0]] ? int'(VECS[v].cycles) : 0;
            else
                exp = 0;
            chk($sformatf("R4 R13 vector %0d code %h", v, VECS[v].code), 8'h24, 32'(exp));
        end

        // R8: slot 1 holds while the master is disabled.
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h6);
        wr(8'h04, 32'h0000_0004);
        idle(4);
        chk("R4 slot1 cycle code", 8'h24, 32'd4);
        wr(8'h00, 32'h0000_0002);
        idle(10);
        chk("R8 slot1 frozen", 8'h24, 32'd5);
        wr(8'h00, 32'h0000_0006);
        idle(3);
        chk("R8 slot1 resumes", 8'h24, 32'd8);

        // R9: master wraps, bank freezes, irq rises.
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h6);
        wr(8'h04, 32'h0000_0004);
        idle(300);
        chk_irq("R9 irq after master wrap", 1'b1);
        chk("R9 master at zero", 8'h20, 32'd0);
        chk("R9 master wrap flag", 8'h00, 32'h0000_0007);
        chk("R9 slot1 frozen at top", 8'h24, 32'd255);
        chk("R9 slot1 no wrap flag", 8'h04, 32'h0000_0006);

        // R10: write with bit 0 set keeps irq; bit 0 clear acknowledges.
        @(negedge clk);
        wr(8'h00, 32'h0000_0007);
        chk_irq("R10 irq kept", 1'b1);
        wr(8'h00, 32'h0000_0006);
        chk_irq("R10 irq acknowledged", 1'b0);
        chk("R10 ctrl0 flag cleared", 8'h00, 32'h0000_0006);

        // R11: slot 1 now wraps on its own without an interrupt.
        idle(3);
        chk("R11 slot1 wrapped and continues", 8'h24, 32'd2);
        chk("R11 slot1 wrap flag", 8'h04, 32'h0000_0007);
        chk_irq("R11 no irq", 1'b0);

        // R12: ID filter on reads and writes.
        @(negedge clk);
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h6);
        wr(8'h30, 32'hFF00_1200);
        chk("R12 filter readback", 8'h30, 32'hFF00_1200);
        @(negedge clk);
        wr(8'h08, 32'h4100_0004);
        wr(8'h0C, 32'h4200_0004);
        rd_txn_valid = 1'b1; rd_txn_id = 16'h12AB;
        wr_txn_valid = 1'b1; wr_txn_id = 16'h12FF;
        @(negedge clk);
        rd_txn_id = 16'h1234;
        wr_txn_id = 16'h0012;
        @(negedge clk);
        rd_txn_id = 16'h13AB;
        wr_txn_valid = 1'b0; wr_txn_id = 16'h1200;
        @(negedge clk);
        rd_txn_valid = 1'b0; rd_txn_id = 16'h1200;
        @(negedge clk);
        rd_txn_id = '0; wr_txn_id = '0;
        chk("R12 filtered reads", 8'h28, 32'd2);
        chk("R12 filtered writes", 8'h2C, 32'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule